// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches a free-running 64-bit system count against a programmable deadline. Once software enables it, the deadline is set to the present count plus a programmed offset. Software pushes the deadline forward by refreshing. If the count reaches the deadline with no refresh, the block raises a stage-one alert, drives an interrupt line and pushes the deadline forward by one more offset period. If that second period also runs out with no refresh, the block raises a stage-two flag. That flag drives the reset request. The stage-two flag survives the ordinary reset that it causes, so that software can later see why the system restarted. Only a separate cold reset clears it.

Software reaches the block over a simple 32-bit register bus that has two frames. The refresh frame carries the refresh register. The control frame carries the control/status word, the offset, the deadline and an identification word. A parameter selects the architecture version. Version 0 has a 32-bit offset, and version 1 has a 48-bit offset that spans two words. The bus carries no data stream, so it has no back-pressure. The block accepts every request in the cycle that `bus_valid` is high. Read data comes back one cycle later, with `bus_rvalid`.

Top module: `wdg_two_stage`

## Requirements
- R1: After `rst_n` and `cold_rst_n`, the block is disabled, both stage flags are clear, and the offset and the deadline read zero.
- R2: The control/status word is at control-frame address 0x000. Bit 0 is the enable, bit 1 is the stage-one flag and bit 2 is the stage-two flag. Each read returns data with `bus_rvalid` exactly one cycle after the request.
- R3: A refresh clears the stage-one flag and loads the deadline with the current count plus the offset. A refresh is caused by any write to refresh-frame address 0x000 (whatever the data), by any write to the control/status word, and by any write to an offset word. An offset write uses the newly written offset.
- R4: When the block is enabled, the stage-one flag is clear and the count is at or past the deadline, the stage-one flag sets. In the same edge the deadline reloads with the count plus the offset. `stage1_irq` follows the flag.
- R5: When the block is enabled, the stage-one flag is set and the count again reaches the deadline, the stage-two flag sets. `stage2_rst_req` follows the flag.
- R6: While the enable is 0, no deadline comparison takes place and both flags hold. Writing 0 to bit 0 of the control/status word stops the block.
- R7: The offset low word is at control-frame address 0x008. With VERSION 1, address 0x00C holds offset bits 47:32 in data bits 15:0, and the upper bits read zero and ignore writes. With VERSION 0, address 0x00C reads zero and ignores writes.
- R8: The deadline is at control-frame addresses 0x010 (low word) and 0x014 (high word). A write there replaces the deadline without a refresh and without changing either flag.
- R9: Address 0xFCC in both frames reads the version number in bits 19:16, with all other bits zero.
- R10: The stage-two flag is unaffected by `rst_n` and is cleared only by `cold_rst_n`.
- R11: In a cycle with a refresh or a deadline write, no expiry is evaluated: the bus write wins.
- R12: Other addresses in either frame read zero, and writes to them have no effect, including no refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of everything except the stage-two flag |
| cold_rst_n | input | 1 | Active-low cold reset, also clears the stage-two flag |
| sys_count | input | 64 | Free-running system count |
| bus_valid | input | 1 | Register request valid, always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = control frame, 1 = refresh frame |
| bus_addr | input | 12 | Byte address within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| stage1_irq | output | 1 | Stage-one alert interrupt |
| stage2_rst_req | output | 1 | Stage-two reset request |

## Verification
The bench tests the deadline at both edges: one count short of it, where nothing may happen, and exactly on it. A design that compares with a strict inequality, or that fails to reload the deadline, fires one tick late or raises both stages together. The bench also writes the bus in the same cycle as an expiry. A design that lets the timer win there asserts the alert despite the refresh. Ordinary resets are issued while stage two is set, to catch a flag that is lost on the very reset it requested. Writes to unused offsets, and to the high offset word on the 32-bit variant, are checked against a design that treats them as a refresh or stores them.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;
  localparam int VER_LSB = 16;
  localparam int VER_W   = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] ADR_OFF_LO = 12'h008;
  localparam logic [ADDR_W-1:0] ADR_OFF_HI = 12'h00C;
  localparam logic [ADDR_W-1:0] ADR_CMP_LO = 12'h010;
  localparam logic [ADDR_W-1:0] ADR_CMP_HI = 12'h014;
  localparam logic [ADDR_W-1:0] ADR_IDENT  = 12'hFCC;
  localparam logic [ADDR_W-1:0] ADR_KICK   = 12'h000;

  typedef enum logic {
    FRAME_CTRL = 1'b0,
    FRAME_KICK = 1'b1
  } frame_e;

  typedef struct packed {
    logic             ctrl_wr;
    logic             kick;
    logic             off_lo_wr;
    logic             off_hi_wr;
    logic             cmp_lo_wr;
    logic             cmp_hi_wr;
    logic [BUS_W-1:0] data;
  } wr_evt_t;

  function automatic logic [BUS_W-1:0] ident_word(input int unsigned ver);
    logic [BUS_W-1:0] w;
    w = '0;
    w[VER_LSB +: VER_W] = VER_W'(ver);
    return w;
  endfunction
endpackage

// File: rtl/wdg_busdec.sv
module wdg_busdec
  import wdg_pkg::*;
#(
  parameter int VERSION = 1
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output wr_evt_t           evt
);
  localparam logic HAS_HI = (VERSION != 0);

  logic wr_ctrl, wr_kick;
  assign wr_ctrl = bus_valid && bus_write && (frame_e'(bus_frame) == FRAME_CTRL);
  assign wr_kick = bus_valid && bus_write && (frame_e'(bus_frame) == FRAME_KICK);

  always_comb begin
    evt           = '0;
    evt.data      = bus_wdata;
    evt.ctrl_wr   = wr_ctrl && (bus_addr == ADR_CTRL);
    evt.kick      = wr_kick && (bus_addr == ADR_KICK);
    evt.off_lo_wr = wr_ctrl && (bus_addr == ADR_OFF_LO);
    evt.off_hi_wr = HAS_HI && wr_ctrl && (bus_addr == ADR_OFF_HI);
    evt.cmp_lo_wr = wr_ctrl && (bus_addr == ADR_CMP_LO);
    evt.cmp_hi_wr = wr_ctrl && (bus_addr == ADR_CMP_HI);
  end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int OFF_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cold_rst_n,
  input  logic [CNT_W-1:0] sys_count,
  input  wr_evt_t          evt,
  output logic             en_o,
  output logic             ws0_o,
  output logic             ws1_o,
  output logic [OFF_W-1:0] offset_o,
  output logic [CNT_W-1:0] compare_o
);
  localparam int PAD_W = CNT_W - OFF_W;
  localparam int CHI_W = CNT_W - BUS_W;

  logic             en_q, ws0_q, ws1_q;
  logic [OFF_W-1:0] off_q, off_lo_upd, off_nxt;
  logic [CNT_W-1:0] cmp_q, cmp_wr_val, reload, off_ext;
  logic             refresh, cmp_wr, expired, stage1_hit, stage2_hit;

  always_comb begin
    off_lo_upd = off_q;
    if (evt.off_lo_wr) off_lo_upd[BUS_W-1:0] = evt.data;
  end

  generate
    if (OFF_W > BUS_W) begin : g_wide
      always_comb begin
        off_nxt = off_lo_upd;
        if (evt.off_hi_wr) off_nxt[OFF_W-1:BUS_W] = evt.data[OFF_W-BUS_W-1:0];
      end
    end else begin : g_narrow
      assign off_nxt = off_lo_upd;
    end
  endgenerate

  assign off_ext = {{PAD_W{1'b0}}, off_q};
  assign reload  = sys_count + {{PAD_W{1'b0}}, off_nxt};
  assign refresh = evt.ctrl_wr | evt.kick | evt.off_lo_wr | evt.off_hi_wr;
  assign cmp_wr  = evt.cmp_lo_wr | evt.cmp_hi_wr;
  assign expired = en_q && (sys_count >= cmp_q) && !refresh && !cmp_wr;
  assign stage1_hit = expired && !ws0_q;
  assign stage2_hit = expired && ws0_q;

  always_comb begin
    cmp_wr_val = cmp_q;
    if (evt.cmp_lo_wr) cmp_wr_val[BUS_W-1:0] = evt.data;
    if (evt.cmp_hi_wr) cmp_wr_val[CNT_W-1:BUS_W] = evt.data[CHI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ws0_q <= 1'b0;
      off_q <= '0;
      cmp_q <= '0;
    end else begin
      off_q <= off_nxt;
      if (evt.ctrl_wr) en_q <= evt.data[0];
      if (refresh) begin
        ws0_q <= 1'b0;
        cmp_q <= reload;
      end else if (cmp_wr) begin
        cmp_q <= cmp_wr_val;
      end else if (stage1_hit) begin
        ws0_q <= 1'b1;
        cmp_q <= reload;
      end
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) ws1_q <= 1'b0;
    else if (stage2_hit) ws1_q <= 1'b1;
  end

  assign en_o      = en_q;
  assign ws0_o     = ws0_q;
  assign ws1_o     = ws1_q;
  assign offset_o  = off_q;
  assign compare_o = cmp_q;

  AST_STAGE2_AFTER_STAGE1: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    $rose(ws1_q) |-> $past(ws0_q)); // R5
  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !ws0_q); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    (!en_q && !refresh && !cmp_wr) |=> ($stable(ws0_q) && $stable(ws1_q))); // R6
  AST_DEADLINE_WRITE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
    (cmp_wr && !refresh) |=> ($stable(ws0_q) && $stable(ws1_q))); // R8
  AST_STAGE1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws0_q) |-> (cmp_q == $past(sys_count) + $past(off_ext))); // R4
  AST_STAGE2_STICKY: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ws1_q |=> ws1_q); // R10
endmodule

// File: rtl/wdg_rdmux.sv
module wdg_rdmux
  import wdg_pkg::*;
#(
  parameter int VERSION = 1,
  parameter int CNT_W   = 64,
  parameter int OFF_W   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              en,
  input  logic              ws0,
  input  logic              ws1,
  input  logic [OFF_W-1:0]  offset,
  input  logic [CNT_W-1:0]  compare,
  output logic              rvalid,
  output logic [BUS_W-1:0]  rdata
);
  localparam logic [BUS_W-1:0] IDENT = ident_word(VERSION);

  logic [BUS_W-1:0] off_hi_word, rd_nxt;
  logic             rd_req;

  generate
    if (OFF_W > BUS_W) begin : g_hi
      assign off_hi_word = BUS_W'(offset[OFF_W-1:BUS_W]);
    end else begin : g_nohi
      assign off_hi_word = '0;
    end
  endgenerate

  assign rd_req = bus_valid && !bus_write;

  always_comb begin
    rd_nxt = '0;
    if (frame_e'(bus_frame) == FRAME_CTRL) begin
      unique case (bus_addr)
        ADR_CTRL:   rd_nxt = {{(BUS_W-3){1'b0}}, ws1, ws0, en};
        ADR_OFF_LO: rd_nxt = offset[BUS_W-1:0];
        ADR_OFF_HI: rd_nxt = off_hi_word;
        ADR_CMP_LO: rd_nxt = compare[BUS_W-1:0];
        ADR_CMP_HI: rd_nxt = BUS_W'(compare[CNT_W-1:BUS_W]);
        ADR_IDENT:  rd_nxt = IDENT;
        default:    rd_nxt = '0;
      endcase
    end else begin
      if (bus_addr == ADR_IDENT) rd_nxt = IDENT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_req;
      rdata  <= rd_req ? rd_nxt : '0;
    end
  end

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid); // R2
  AST_IDENT_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr == ADR_IDENT) |=> (rdata[VER_LSB +: VER_W] == VER_W'(VERSION))); // R9
endmodule

// File: rtl/wdg_two_stage.sv
module wdg_two_stage
  import wdg_pkg::*;
#(
  parameter int VERSION = 1,
  parameter int CNT_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cold_rst_n,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              bus_rvalid,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              stage1_irq,
  output logic              stage2_rst_req
);
  localparam int OFF_W = (VERSION == 0) ? 32 : 48;

  wr_evt_t          evt;
  logic             en, ws0, ws1;
  logic [OFF_W-1:0] offset;
  logic [CNT_W-1:0] compare;

  wdg_busdec #(.VERSION(VERSION)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_frame (bus_frame),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt       (evt)
  );

  wdg_core #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cold_rst_n (cold_rst_n),
    .sys_count  (sys_count),
    .evt        (evt),
    .en_o       (en),
    .ws0_o      (ws0),
    .ws1_o      (ws1),
    .offset_o   (offset),
    .compare_o  (compare)
  );

  wdg_rdmux #(.VERSION(VERSION), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_frame (bus_frame),
    .bus_addr  (bus_addr),
    .en        (en),
    .ws0       (ws0),
    .ws1       (ws1),
    .offset    (offset),
    .compare   (compare),
    .rvalid    (bus_rvalid),
    .rdata     (bus_rdata)
  );

  assign stage1_irq     = ws0;
  assign stage2_rst_req = ws1;
endmodule

// File: tb/tb_wdg_two_stage.sv
module tb_wdg_two_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cold_n = 1'b0;
  logic [63:0] cnt = 64'd1000;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_frame = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rvalid, irq, rreq;
  logic [31:0] rdata;
  logic        v0_rvalid, v0_irq, v0_rreq;
  logic [31:0] v0_rdata;

  int unsigned inc = 1;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] last_rd, last_v0;

  bit          m_en, m_ws0, m_ws1;
  logic [63:0] m_off, m_cmp;

  always #10 clk = ~clk;

  wdg_two_stage #(.VERSION(1)) dut (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_n), .sys_count(cnt),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(rvalid),
    .bus_rdata(rdata), .stage1_irq(irq), .stage2_rst_req(rreq));

  wdg_two_stage #(.VERSION(0)) dut_v0 (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_n), .sys_count(cnt),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(v0_rvalid),
    .bus_rdata(v0_rdata), .stage1_irq(v0_irq), .stage2_rst_req(v0_rreq));

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input bit f, input logic [11:0] a);
    if (a == 12'hFCC) return 32'h0001_0000;
    if (f) return 32'h0;
    case (a)
      12'h000: return {29'b0, m_ws1, m_ws0, m_en};
      12'h008: return m_off[31:0];
      12'h00C: return {16'b0, m_off[47:32]};
      12'h010: return m_cmp[31:0];
      12'h014: return m_cmp[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_update(input bit v, input bit w, input bit f,
                          input logic [11:0] a, input logic [31:0] d);
    bit cw, kk, ol, oh, cl, ch, rf, cm, ex, wr;
    logic [63:0] no;
    if (!rst_n) begin
      m_en = 0; m_ws0 = 0; m_off = '0; m_cmp = '0;
    end else begin
      wr = v && w;
      cw = wr && !f && a == 12'h000;
      kk = wr &&  f && a == 12'h000;
      ol = wr && !f && a == 12'h008;
      oh = wr && !f && a == 12'h00C;
      cl = wr && !f && a == 12'h010;
      ch = wr && !f && a == 12'h014;
      no = m_off;
      if (ol) no[31:0] = d;
      if (oh) no[47:32] = d[15:0];
      rf = cw | kk | ol | oh;
      cm = cl | ch;
      ex = m_en && (cnt >= m_cmp) && !rf && !cm;
      if (ex && m_ws0) m_ws1 = 1;
      if (rf) begin
        m_ws0 = 0; m_cmp = cnt + no;
      end else if (cm) begin
        if (cl) m_cmp[31:0] = d;
        if (ch) m_cmp[63:32] = d;
      end else if (ex && !m_ws0) begin
        m_ws0 = 1; m_cmp = cnt + no;
      end
      if (cw) m_en = d[0];
      m_off = no;
    end
    if (!cold_n) m_ws1 = 0;
  endtask

  task automatic cyc(input bit v, input bit w, input bit f,
                     input logic [11:0] a, input logic [31:0] d);
    logic [31:0] er;
    bit isr;
    bus_valid = v; bus_write = w; bus_frame = f; bus_addr = a; bus_wdata = d;
    er  = m_read(f, a);
    isr = v && !w && rst_n;
    @(posedge clk);
    m_update(v, w, f, a, d);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    check("R4 stage1_irq", {63'b0, irq}, {63'b0, m_ws0});
    check("R5 stage2_rst_req", {63'b0, rreq}, {63'b0, m_ws1});
    check("R2 read strobe", {63'b0, rvalid}, {63'b0, isr});
    if (isr) check("R2 read data", {32'b0, rdata}, {32'b0, er});
    last_rd = rdata;
    last_v0 = v0_rdata;
    cnt = cnt + 64'(inc);
  endtask

  task automatic wr(input bit f, input logic [11:0] a, input logic [31:0] d);
    cyc(1, 1, f, a, d);
  endtask
  task automatic rd(input bit f, input logic [11:0] a);
    cyc(1, 0, f, a, 32'h0);
  endtask
  task automatic idle();
    cyc(0, 0, 0, 12'h0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    m_en = 0; m_ws0 = 0; m_ws1 = 0; m_off = '0; m_cmp = '0;
    @(negedge clk);
    idle(); idle();
    rst_n = 1; cold_n = 1;
    inc = 0;
    // R1 reset state
    rd(0, 12'h000); check("R1 status after reset", last_rd, 0);
    rd(0, 12'h010); check("R1 deadline after reset", last_rd, 0);
    rd(0, 12'h008); check("R1 offset after reset", last_rd, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 reset request after reset", rreq, 0);
    // R9 ident in both frames, both versions
    rd(0, 12'hFCC); check("R9 ident control frame", last_rd, 32'h0001_0000);
    check("R9 ident version 0", last_v0, 32'h0);
    rd(1, 12'hFCC); check("R9 ident refresh frame", last_rd, 32'h0001_0000);
    // R7 offset width
    wr(0, 12'h008, 32'hFFFF_FFFF);
    wr(0, 12'h00C, 32'hABCD_1234);
    rd(0, 12'h00C); check("R7 offset high word v1", last_rd, 32'h0000_1234);
    check("R7 offset high word v0 reads zero", last_v0, 32'h0);
    rd(0, 12'h008); check("R7 offset low word v0", last_v0, 32'hFFFF_FFFF);
    // R3 enable and deadline load; R4 boundary; R5 second stage
    cnt = 64'd1000;
    wr(0, 12'h00C, 32'h0);
    wr(0, 12'h008, 32'd20);
    wr(0, 12'h000, 32'h1);
    rd(0, 12'h010); check("R3 deadline after enable", last_rd, 32'd1020);
    cnt = 64'd1019; idle(); check("R4 one tick before deadline", irq, 0);
    cnt = 64'd1020; idle(); check("R4 alert at deadline", irq, 1);
    check("R5 no reset at first expiry", rreq, 0);
    rd(0, 12'h010); check("R4 deadline reloaded", last_rd, 32'd1040);
    cnt = 64'd1039; idle(); check("R5 one tick before second deadline", rreq, 0);
    cnt = 64'd1040; idle(); check("R5 reset request at second deadline", rreq, 1);
    rd(0, 12'h000); check("R2 status bits all set", last_rd, 32'h7);
    // R10 survive ordinary reset
    rst_n = 0; idle(); rst_n = 1;
    check("R10 reset request survives rst_n", rreq, 1);
    check("R1 irq cleared by rst_n", irq, 0);
    rd(0, 12'h000); check("R10 status after rst_n", last_rd, 32'h4);
    cold_n = 0; idle(); cold_n = 1;
    check("R10 cold reset clears stage two", rreq, 0);
    // R6 disabled: no comparison
    cnt = 64'd5000;
    wr(0, 12'h008, 32'd10);
    wr(0, 12'h000, 32'h1);
    wr(0, 12'h000, 32'h0);
    cnt = 64'd9000; idle(); idle();
    check("R6 no alert while disabled", irq, 0);
    rd(0, 12'h000); check("R6 status disabled", last_rd, 32'h0);
    // R8 deadline write
    wr(0, 12'h000, 32'h1);
    wr(0, 12'h010, 32'd9003);
    check("R8 deadline write leaves alert clear", irq, 0);
    cnt = 64'd9003; idle(); check("R8 new deadline honoured", irq, 1);
    wr(0, 12'h010, 32'd9100);
    check("R8 deadline write keeps alert", irq, 1);
    rd(0, 12'h010); check("R8 deadline readback", last_rd, 32'd9100);
    // R11 bus write wins over same-cycle expiry
    cnt = 64'd9100;
    wr(1, 12'h000, 32'h0);
    check("R11 refresh wins over expiry", irq, 0);
    check("R11 no stage two", rreq, 0);
    rd(0, 12'h010); check("R11 deadline from refresh", last_rd, 32'd9110);
    // R12 unused addresses
    cnt = 64'd9110;
    wr(1, 12'h008, 32'h1);
    check("R12 unused refresh address is not a refresh", irq, 1);
    rd(1, 12'h000); check("R12 refresh register reads zero", last_rd, 0);
    rd(0, 12'h020); check("R12 unused control address reads zero", last_rd, 0);
    // R3 refresh with arbitrary data, then via offset write
    wr(1, 12'h000, 32'hDEAD_BEEF);
    check("R3 refresh data ignored, alert cleared", irq, 0);
    cnt = 64'd9200; idle(); check("R3 alert again", irq, 1);
    wr(0, 12'h008, 32'd30);
    check("R3 offset write refreshes", irq, 0);
    rd(0, 12'h010); check("R3 deadline uses new offset", last_rd, 32'd9230);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom % 16;
      inc = $urandom % 4;
      case (r)
        0, 1: wr(0, 12'h000, {31'b0, ($urandom % 4) != 0});
        2:    wr(1, 12'h000, $urandom);
        3:    wr(0, 12'h008, 32'd1 + ($urandom % 40));
        4:    wr(0, 12'h00C, (($urandom % 8) == 0) ? $urandom : 32'h0);
        5:    wr(0, 12'h010, cnt[31:0] + ($urandom % 50));
        6:    wr(0, 12'h014, cnt[63:32]);
        7, 8, 9: begin
          case ($urandom % 7)
            0: rd(0, 12'h000);
            1: rd(0, 12'h008);
            2: rd(0, 12'h00C);
            3: rd(0, 12'h010);
            4: rd(0, 12'h014);
            5: rd(1, 12'hFCC);
            default: rd(1, 12'h000);
          endcase
        end
        10: wr(1, 12'h008 + 12'(4 * ($urandom % 4)), $urandom);
        11: begin
          if (($urandom % 8) == 0) begin
            rst_n = 0; idle(); rst_n = 1;
          end else idle();
        end
        12: begin
          if (($urandom % 10) == 0) begin
            cold_n = 0; idle(); cold_n = 1;
          end else idle();
        end
        14: begin cnt = cnt + 64'($urandom % 200); idle(); end
        default: idle();
      endcase
    end
    report();
    $finish;
  end
endmodule